// File: doc/BRIEF.md
# Address Line 20 Gate and Warm Reset Emulator

This block watches the I/O write traffic of a legacy-compatible CPU and reproduces, with no real keyboard controller present, the two ways of switching the A20 address gate and of asking for a CPU warm reset. The first way is a two-step sequence. A command byte written to port 64h arms the block, and the next write to port 60h carries the new gate level. The same port 64h also takes a reset command that is recognised from a partial bit pattern. The second way is a system control register at port 92h. Bit 1 of that register drives the gate directly, and a rising edge on bit 0 requests a reset.

The gate output is ANDed with the CPU's address bit 20 before the bit reaches memory. When the gate is closed, addresses wrap at 1 MB. A two-bit mode input chooses which path may act: the keyboard-controller path only, the port 92h path only, or both. Reset requests from either path produce one fixed-length reset pulse.

The I/O write port has no back-pressure. A write is a single-cycle strobe that is consumed in the cycle it is seen, and there is no ready signal. All other pins are plain levels.

Top module: `a20_gate_emu`

## Requirements
- R1: After reset, `a20_en` is 0, `cpu_reset` is 0, `p92_rdata` is 0 and the block is not armed, so a port 60h write that follows has no effect.
- R2: A port 64h write of D1h arms the block. The next port 60h write sets `a20_en` to bit 1 of its data (02h opens the gate, 00h closes it) and disarms the block, so a further port 60h write has no effect.
- R3: A port 60h write made while not armed leaves `a20_en` unchanged. `a20_en` changes only in the cycle after an I/O write.
- R4: While armed, any port 64h write other than D1h cancels the armed state, and the port 60h write that follows is ignored.
- R5: A port 64h write whose data matches 1111xxx0b (for example FEh or F0h) starts a reset pulse. Other values, such as FFh or EEh, do not start one.
- R6: When the port 92h path is enabled, a port 92h write sets `a20_en` to bit 1 of its data.
- R7: When the port 92h path is enabled, a port 92h write starts a reset pulse only if it changes the stored bit 0 from 0 to 1. Writing 1 while the stored bit is already 1 does nothing.
- R8: `p92_rdata` returns the current gate level in bit 1, the stored port 92h bit 0 in bit 0, and zeros in all other bits.
- R9: `mem_addr20` is high only when `cpu_addr20` is high and the gate is open.
- R10: `cpu_reset` stays high for exactly 16 clocks. A reset request that arrives while the pulse is active is dropped and does not extend the pulse.
- R11: The mode encoding is as follows. 00 enables the keyboard-controller path only, and port 92h writes are ignored entirely. 01 enables the port 92h path only, and port 60h/64h writes are ignored entirely. 10 and 11 enable both paths.
- R12: A write is sampled on a rising clock edge, and `a20_en` and `cpu_reset` show its effect from that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O port address of the write |
| io_wdata | input | 8 | I/O write data |
| mode | input | 2 | Path select: 00 keyboard-controller only, 01 port 92h only, 1x both |
| cpu_addr20 | input | 1 | Address bit 20 from the CPU |
| a20_en | output | 1 | Gate level (1 = open) |
| mem_addr20 | output | 1 | Gated address bit 20 toward memory |
| cpu_reset | output | 1 | Warm reset pulse toward the CPU |
| p92_rdata | output | 8 | Readback value of port 92h |

## Verification
Gate switching and reset generation can happen in the same cycle. A single port 92h write of 03h, made while the stored bit 0 is clear, both opens the gate and starts a reset pulse. The bench makes that write and then samples `a20_en`, `cpu_reset` and `p92_rdata` together one cycle later. A second collision is a reset command that arrives while a pulse is already running. The bench issues that command partway through an active pulse and measures the total high time, which must still be 16 clocks.

// File: rtl/a20_pkg.sv
package a20_pkg;

  typedef enum logic [1:0] {
    GATE_KBC_ONLY = 2'b00,
    GATE_P92_ONLY = 2'b01,
    GATE_BOTH     = 2'b10,
    GATE_BOTH_ALT = 2'b11
  } gate_mode_e;

  function automatic logic kbc_path_on(input gate_mode_e m);
    return (m != GATE_P92_ONLY);
  endfunction

  function automatic logic p92_path_on(input gate_mode_e m);
    return (m != GATE_KBC_ONLY);
  endfunction

endpackage

// File: rtl/a20_kbc_seq.sv
module a20_kbc_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h0064,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
  parameter logic [DATA_W-1:0] ARM_CODE  = 8'hD1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              gate_we,
  output logic              gate_val,
  output logic              rst_req
);

  logic armed_q;
  logic cmd_hit, data_hit;

  assign cmd_hit  = en && wr && (addr == CMD_PORT);
  assign data_hit = en && wr && (addr == DATA_PORT);

  // Second step of the sequence: only honoured while armed.
  assign gate_we  = data_hit && armed_q;
  assign gate_val = wdata[1];

  // Reset command: upper nibble all ones, bit 0 clear, bits 3..1 don't care.
  assign rst_req  = cmd_hit && (wdata[7:4] == 4'hF) && !wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (cmd_hit) begin
      armed_q <= (wdata == ARM_CODE);
    end else if (data_hit) begin
      armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/a20_sysctl_port.sv
module a20_sysctl_port #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTL_PORT = 16'h0092
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wbits,
  output logic              gate_we,
  output logic              gate_val,
  output logic              rst_req,
  output logic              bit0_q
);

  logic hit;

  assign hit      = en && wr && (addr == CTL_PORT);
  assign gate_we  = hit;
  assign gate_val = wbits[1];
  assign rst_req  = hit && wbits[0] && !bit0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit0_q <= 1'b0;
    end else if (hit) begin
      bit0_q <= wbits[0];
    end
  end

endmodule

// File: rtl/a20_reset_pulse.sv
module a20_reset_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);

  generate
    if (PULSE_LEN <= 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= trig && !pulse;
      end
    end else begin : g_count
      localparam int CW = $clog2(PULSE_LEN);
      localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);
      logic [CW-1:0] left_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pulse  <= 1'b0;
          left_q <= '0;
        end else if (!pulse) begin
          if (trig) begin
            pulse  <= 1'b1;
            left_q <= LAST;
          end
        end else if (left_q == '0) begin
          pulse <= 1'b0;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/a20_gate_emu.sv
module a20_gate_emu #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PULSE_LEN = 16,
  parameter logic [ADDR_W-1:0] KBC_CMD_PORT  = 16'h0064,
  parameter logic [ADDR_W-1:0] KBC_DATA_PORT = 16'h0060,
  parameter logic [ADDR_W-1:0] SYSCTL_PORT   = 16'h0092,
  parameter logic [DATA_W-1:0] ARM_CODE      = 8'hD1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic [1:0]        mode,
  input  logic              cpu_addr20,
  output logic              a20_en,
  output logic              mem_addr20,
  output logic              cpu_reset,
  output logic [DATA_W-1:0] p92_rdata
);
  import a20_pkg::*;

  gate_mode_e mode_e;
  logic kbc_on, p92_on;
  logic k_we, k_val, k_rst;
  logic s_we, s_val, s_rst, s_bit0;

  assign mode_e = gate_mode_e'(mode);
  assign kbc_on = kbc_path_on(mode_e);
  assign p92_on = p92_path_on(mode_e);

  a20_kbc_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CMD_PORT(KBC_CMD_PORT), .DATA_PORT(KBC_DATA_PORT), .ARM_CODE(ARM_CODE)
  ) u_kbc (
    .clk(clk), .rst_n(rst_n), .en(kbc_on), .wr(io_wr),
    .addr(io_addr), .wdata(io_wdata),
    .gate_we(k_we), .gate_val(k_val), .rst_req(k_rst)
  );

  a20_sysctl_port #(
    .ADDR_W(ADDR_W), .CTL_PORT(SYSCTL_PORT)
  ) u_p92 (
    .clk(clk), .rst_n(rst_n), .en(p92_on), .wr(io_wr),
    .addr(io_addr), .wbits(io_wdata[1:0]),
    .gate_we(s_we), .gate_val(s_val), .rst_req(s_rst), .bit0_q(s_bit0)
  );

  a20_reset_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(k_rst || s_rst), .pulse(cpu_reset)
  );

  // Both write enables decode different ports, so they never coincide.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    a20_en <= 1'b0;
    else if (k_we) a20_en <= k_val;
    else if (s_we) a20_en <= s_val;
  end

  assign mem_addr20 = cpu_addr20 & a20_en;
  assign p92_rdata  = {{(DATA_W-2){1'b0}}, a20_en, s_bit0};

endmodule

// File: rtl/a20_gate_emu_chk.sv
module a20_gate_emu_chk #(
  parameter int ADDR_W    = 16,
  parameter int PULSE_LEN = 16,
  parameter logic [ADDR_W-1:0] P60 = 16'h0060,
  parameter logic [ADDR_W-1:0] P64 = 16'h0064,
  parameter logic [ADDR_W-1:0] P92 = 16'h0092
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic              wbit1,
  input logic [1:0]        mode,
  input logic              a20_en,
  input logic              cpu_reset
);
  localparam int CW = $clog2(PULSE_LEN + 1) + 1;
  localparam logic [CW-1:0] LEN_V = CW'(PULSE_LEN);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= '0;
    else if (cpu_reset) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  assert_gate_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(a20_en) |-> $past(io_wr));

  assert_kbc_mode_drops_p92_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == P92 && mode == 2'b00) |=> $stable(a20_en));

  assert_p92_mode_drops_kbc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (io_addr == P60 || io_addr == P64) && mode == 2'b01)
      |=> ($stable(a20_en) && !$rose(cpu_reset)));

  assert_p92_sets_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == P92 && mode != 2'b00) |=> (a20_en == $past(wbit1)));

  assert_pulse_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_reset) |-> $past(io_wr));

  assert_pulse_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |-> (hi_cnt < LEN_V));

  assert_pulse_exact_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_reset) |-> (hi_cnt == LEN_V));

endmodule

bind a20_gate_emu a20_gate_emu_chk #(
  .ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN),
  .P60(KBC_DATA_PORT), .P64(KBC_CMD_PORT), .P92(SYSCTL_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
  .wbit1(io_wdata[1]), .mode(mode), .a20_en(a20_en), .cpu_reset(cpu_reset)
);

// File: tb/a20_gate_emu_test.sv
module a20_gate_emu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [1:0]  mode = 2'b00;
  logic        cpu_addr20 = 1'b0;
  logic        a20_en, mem_addr20, cpu_reset;
  logic [7:0]  p92_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  a20_gate_emu uut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .mode(mode), .cpu_addr20(cpu_addr20),
    .a20_en(a20_en), .mem_addr20(mem_addr20), .cpu_reset(cpu_reset),
    .p92_rdata(p92_rdata)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic [15:0] a;
    logic [7:0]  d;
    logic        gate;
  } vec_t;

  // Mode 00 = keyboard path, 01 = port 92h path, 1x = both.
  localparam vec_t VEC [21] = '{
    '{2'b00, 16'h0060, 8'h02, 1'b0},  // R3 unarmed data write
    '{2'b00, 16'h0064, 8'hD1, 1'b0},  // R2 arm
    '{2'b00, 16'h0060, 8'h02, 1'b1},  // R2 open
    '{2'b00, 16'h0060, 8'h00, 1'b1},  // R2 arm consumed
    '{2'b00, 16'h0064, 8'hD1, 1'b1},
    '{2'b00, 16'h0060, 8'h00, 1'b0},  // R2 close
    '{2'b00, 16'h0092, 8'h02, 1'b0},  // R11 92h ignored
    '{2'b00, 16'h0064, 8'hD1, 1'b0},
    '{2'b00, 16'h0064, 8'hAB, 1'b0},  // R4 cancel
    '{2'b00, 16'h0060, 8'h02, 1'b0},  // R4 ignored after cancel
    '{2'b01, 16'h0092, 8'h02, 1'b1},  // R6 direct open
    '{2'b01, 16'h0064, 8'hD1, 1'b1},  // R11 arm ignored
    '{2'b01, 16'h0060, 8'h00, 1'b1},  // R11 data ignored
    '{2'b01, 16'h0092, 8'h00, 1'b0},  // R6 direct close
    '{2'b10, 16'h0092, 8'h02, 1'b1},  // R11 both: 92h
    '{2'b10, 16'h0064, 8'hD1, 1'b1},
    '{2'b10, 16'h0060, 8'h00, 1'b0},  // R11 both: 60h/64h
    '{2'b10, 16'h0060, 8'h02, 1'b0},  // R3 unarmed
    '{2'b11, 16'h0092, 8'h02, 1'b1},  // R11 mode 11
    '{2'b00, 16'h0064, 8'hD1, 1'b1},
    '{2'b00, 16'h0060, 8'hFD, 1'b0}   // R2 only bit 1 counts
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr  = a;
    io_wdata = d;
    io_wr    = 1'b1;
    @(negedge clk);
    io_wr    = 1'b0;
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (cpu_reset && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cpu_addr20 = 1'b1;
    #0;
    check("R1 gate", a20_en, 0);
    check("R1 reset out", cpu_reset, 0);
    check("R1 readback", p92_rdata, 8'h00);
    check("R9 closed gate", mem_addr20, 0);

    for (int i = 0; i < 21; i++) begin
      mode = VEC[i].m;
      wr(VEC[i].a, VEC[i].d);
      check($sformatf("R2/R3/R4/R6/R11 vector %0d gate", i), a20_en, VEC[i].gate);
      check($sformatf("R5 vector %0d no reset", i), cpu_reset, 0);
    end

    // R9 gated address
    mode = 2'b01;
    wr(16'h0092, 8'h02);
    check("R9 open gate passes", mem_addr20, 1);
    cpu_addr20 = 1'b0;
    #0;
    check("R9 low input", mem_addr20, 0);
    cpu_addr20 = 1'b1;
    wr(16'h0092, 8'h00);
    check("R9 closed again", mem_addr20, 0);

    // R5 / R10 / R12 reset command decode and length
    mode = 2'b00;
    wr(16'h0064, 8'hFE);
    check("R12 reset seen after edge", cpu_reset, 1);
    pulse_len(n);
    check("R10 pulse length FE", n, 16);
    wr(16'h0064, 8'hF0);
    check("R5 F0 fires", cpu_reset, 1);
    pulse_len(n);
    check("R10 pulse length F0", n, 16);
    wr(16'h0064, 8'hFF);
    check("R5 FF no reset", cpu_reset, 0);
    wr(16'h0064, 8'hEE);
    check("R5 EE no reset", cpu_reset, 0);

    // R10 no retrigger
    wr(16'h0064, 8'hFE);
    n = 0;
    while (cpu_reset && n < 100) begin
      if (n == 5) begin
        io_addr = 16'h0064; io_wdata = 8'hFE; io_wr = 1'b1;
      end else begin
        io_wr = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    io_wr = 1'b0;
    check("R10 retrigger ignored length", n, 16);
    repeat (3) @(negedge clk);
    check("R10 no queued pulse", cpu_reset, 0);

    // R7 / R8 port 92h bit 0
    mode = 2'b01;
    wr(16'h0092, 8'h01);
    check("R7 rising bit0 fires", cpu_reset, 1);
    check("R8 readback 01", p92_rdata, 8'h01);
    pulse_len(n);
    wr(16'h0092, 8'h01);
    check("R7 bit0 held no reset", cpu_reset, 0);
    wr(16'h0092, 8'h00);
    wr(16'h0092, 8'h03);
    check("R7 same-cycle reset", cpu_reset, 1);
    check("R6 same-cycle gate", a20_en, 1);
    check("R8 readback 03", p92_rdata, 8'h03);
    pulse_len(n);
    check("R10 combined pulse length", n, 16);

    // R11 path isolation
    wr(16'h0064, 8'hFE);
    check("R11 p92 mode drops 64h reset", cpu_reset, 0);
    mode = 2'b00;
    wr(16'h0092, 8'h00);
    check("R11 kbc mode readback kept", p92_rdata, 8'h03);
    check("R11 kbc mode gate kept", a20_en, 1);
    mode = 2'b10;
    wr(16'h0092, 8'h00);
    check("R8 both mode readback 00", p92_rdata, 8'h00);
    wr(16'h0092, 8'h01);
    check("R11 both mode 92h reset", cpu_reset, 1);
    pulse_len(n);
    wr(16'h0064, 8'hFE);
    check("R11 both mode 64h reset", cpu_reset, 1);
    pulse_len(n);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R10: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule